// File: doc/BRIEF.md
# Dead-Time Efficiency Tracker

This block tunes one dead-time edge of a synchronous switching stage by a slow perturb-and-observe search. It never works out an absolute efficiency. Instead it watches the averaged input current, which falls as efficiency rises. After each step it checks whether that step lowered or raised the current, and it uses the answer to pick the direction of the next step.

Current samples arrive with a valid strobe. The block collects a power-of-two count of them and forms their mean. It compares each mean with the one before it. A change no larger than a programmable dead band counts as no change. The dead-time word moves by a programmable step and always stays between programmable limits.

The search is taken to have found the minimum when the direction flips on two updates in a row. At that point a converged flag is raised and the dead time is frozen. It stays frozen until a restart pulse begins a new search. One instance serves one edge, for example the turn-on edge.

Top module: `dt_grad_tracker`

## Requirements
- R1: While `rst` or `restart` is high, the dead time loads `dt_max`, `dir_down` reads 1 (1 means decreasing, 0 means increasing) and `converged` reads 0.
- R2: A mean is formed only after 2^AVG_K valid samples, as the sum shifted right by AVG_K (floor). With fewer samples the dead time does not change.
- R3: The first mean after reset or restart only becomes the reference. It triggers one probe step downward.
- R4: If the mean falls below the reference by more than `dead_band`, the dead time steps again in the present direction.
- R5: If the mean rises above the reference by more than `dead_band`, the direction flag inverts and the dead time steps in the new direction.
- R6: If the mean differs from the reference by no more than `dead_band` (equality included), no step is taken and the direction is kept. The reference always takes the newest mean.
- R7: A step that would cross `dt_min` or `dt_max` stops exactly on that limit.
- R8: On the second direction reversal in a row, `converged` goes to 1. On that update the dead time does not move, and `dir_down` shows the reversed direction.
- R9: While converged, further means leave the dead time and the flags unchanged until `restart`.
- R10: The dead time changes only one cycle after a completed mean, and never by more than `step_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Clears the search and starts over from `dt_max` |
| cur_valid | input | 1 | Qualifies `cur_sample` |
| cur_sample | input | CUR_W | Averaged input-current sample |
| step_size | input | DT_W | Dead-time step per update |
| dt_min | input | DT_W | Lower dead-time limit |
| dt_max | input | DT_W | Upper dead-time limit and start value |
| dead_band | input | CUR_W | Largest current change treated as no change |
| dead_time | output | DT_W | Current dead-time setting |
| dir_down | output | 1 | 1 when the search moves toward smaller dead time |
| converged | output | 1 | Minimum found; dead time frozen |

## Verification
The bench targets the corners where the search logic is easy to get wrong.

- A change exactly equal to the dead band must not cause a step. A design that uses a strict compare in the wrong place would step and wander.
- Steps that land past either limit must stop on the limit. A design without the clamp would wrap, or leave the programmed range.
- A no-change update that sits between two reversals must not break the reversal chain, while a same-direction step must break it. Getting this wrong either declares convergence too early or never declares it.
- Three samples must not produce an update, and the mean must be formed from unequal samples. An averager with an off-by-one count would step early.
- After convergence, new means must leave the dead time unchanged.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Outcome of comparing a new current mean with the stored reference
    typedef enum logic [1:0] {
        TR_FLAT = 2'd0,
        TR_FALL = 2'd1,
        TR_RISE = 2'd2
    } trend_e;

    // Control state of the search
    typedef struct packed {
        logic       have_ref;
        logic       dir_down;
        logic [1:0] rev_cnt;
        logic       conv;
    } ctl_t;

    localparam ctl_t CTL_INIT = '{have_ref: 1'b0, dir_down: 1'b1, rev_cnt: 2'd0, conv: 1'b0};

    // Number of back-to-back reversals that marks the minimum
    localparam logic [1:0] REV_LIMIT = 2'd2;

endpackage

// File: rtl/dtg_averager.sv
module dtg_averager #(
    parameter int W = 12,
    parameter int K = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_mean
);
    localparam int SUM_W = W + K;
    localparam int CNT_W = (K > 0) ? K : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << K) - 1);

    logic [SUM_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    logic [SUM_W-1:0] sum_next;
    logic [SUM_W-1:0] shifted;

    assign sum_next = acc + SUM_W'(in_data);
    assign shifted  = sum_next >> K;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc       <= '0;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_mean  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                if (cnt == LAST) begin
                    out_mean  <= shifted[W-1:0];
                    out_valid <= 1'b1;
                    acc       <= '0;
                    cnt       <= '0;
                end else begin
                    acc <= sum_next;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dtg_slope.sv
module dtg_slope
    import dtg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] mean,
    input  logic [W-1:0] ref_mean,
    input  logic [W-1:0] band,
    output trend_e       trend
);
    logic [W-1:0] mag;
    logic         up;

    always_comb begin
        up  = (mean > ref_mean);
        mag = up ? (mean - ref_mean) : (ref_mean - mean);
        if (mag <= band)
            trend = TR_FLAT;
        else if (up)
            trend = TR_RISE;
        else
            trend = TR_FALL;
    end
endmodule

// File: rtl/dtg_stepper.sv
module dtg_stepper
    import dtg_pkg::*;
#(
    parameter int DT_W  = 10,
    parameter int CUR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             upd,
    input  logic [CUR_W-1:0] mean,
    input  trend_e           trend,
    input  logic [DT_W-1:0]  step_size,
    input  logic [DT_W-1:0]  dt_min,
    input  logic [DT_W-1:0]  dt_max,
    output logic [CUR_W-1:0] ref_mean,
    output logic [DT_W-1:0]  dead_time,
    output logic             dir_down,
    output logic             converged
);
    localparam int EW = DT_W + 1;

    ctl_t            ctl;
    logic [DT_W-1:0] dt_up;
    logic [DT_W-1:0] dt_dn;
    logic [EW-1:0]   sum_up;
    logic [EW-1:0]   floor_dn;

    // Clamped candidates in both directions
    always_comb begin
        sum_up   = EW'(dead_time) + EW'(step_size);
        floor_dn = EW'(dt_min) + EW'(step_size);
        dt_up    = (sum_up > EW'(dt_max)) ? dt_max : sum_up[DT_W-1:0];
        dt_dn    = (EW'(dead_time) < floor_dn) ? dt_min : (dead_time - step_size);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ctl       <= CTL_INIT;
            dead_time <= dt_max;
            ref_mean  <= '0;
        end else if (upd && !ctl.conv) begin
            ref_mean <= mean;
            if (!ctl.have_ref) begin
                ctl.have_ref <= 1'b1;
                dead_time    <= dt_dn;
            end else begin
                unique case (trend)
                    TR_FALL: begin
                        ctl.rev_cnt <= 2'd0;
                        dead_time   <= ctl.dir_down ? dt_dn : dt_up;
                    end
                    TR_RISE: begin
                        ctl.dir_down <= ~ctl.dir_down;
                        if (ctl.rev_cnt == REV_LIMIT - 2'd1) begin
                            ctl.rev_cnt <= REV_LIMIT;
                            ctl.conv    <= 1'b1;
                        end else begin
                            ctl.rev_cnt <= ctl.rev_cnt + 2'd1;
                            dead_time   <= ctl.dir_down ? dt_up : dt_dn;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign dir_down  = ctl.dir_down;
    assign converged = ctl.conv;
endmodule

// File: rtl/dt_grad_tracker.sv
module dt_grad_tracker
    import dtg_pkg::*;
#(
    parameter int CUR_W = 12,
    parameter int DT_W  = 10,
    parameter int AVG_K = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             cur_valid,
    input  logic [CUR_W-1:0] cur_sample,
    input  logic [DT_W-1:0]  step_size,
    input  logic [DT_W-1:0]  dt_min,
    input  logic [DT_W-1:0]  dt_max,
    input  logic [CUR_W-1:0] dead_band,
    output logic [DT_W-1:0]  dead_time,
    output logic             dir_down,
    output logic             converged
);
    logic             avg_valid;
    logic [CUR_W-1:0] avg_mean;
    logic [CUR_W-1:0] ref_mean;
    trend_e           trend;

    dtg_averager #(.W(CUR_W), .K(AVG_K)) u_avg (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .in_valid (cur_valid),
        .in_data  (cur_sample),
        .out_valid(avg_valid),
        .out_mean (avg_mean)
    );

    dtg_slope #(.W(CUR_W)) u_slope (
        .mean    (avg_mean),
        .ref_mean(ref_mean),
        .band    (dead_band),
        .trend   (trend)
    );

    dtg_stepper #(.DT_W(DT_W), .CUR_W(CUR_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .upd      (avg_valid),
        .mean     (avg_mean),
        .trend    (trend),
        .step_size(step_size),
        .dt_min   (dt_min),
        .dt_max   (dt_max),
        .ref_mean (ref_mean),
        .dead_time(dead_time),
        .dir_down (dir_down),
        .converged(converged)
    );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int DT_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            restart,
    input logic            avg_valid,
    input logic [DT_W-1:0] dead_time,
    input logic [DT_W-1:0] step_size,
    input logic [DT_W-1:0] dt_min,
    input logic [DT_W-1:0] dt_max,
    input logic            converged
);
    // R7: every stepped value lies inside the limits
    a_r7_within_limits: assert property (@(posedge clk) disable iff (rst)
        (dead_time != $past(dead_time) && !$past(restart) && !$past(rst))
            |-> (dead_time >= dt_min && dead_time <= dt_max));

    // R10: a step never exceeds the programmed size
    a_r10_step_bounded: assert property (@(posedge clk) disable iff (rst)
        (dead_time != $past(dead_time) && !$past(restart) && !$past(rst))
            |-> ((dead_time > $past(dead_time) ? dead_time - $past(dead_time)
                                               : $past(dead_time) - dead_time) <= $past(step_size)));

    // R10: dead time moves only after a completed mean
    a_r10_step_on_update: assert property (@(posedge clk) disable iff (rst)
        (dead_time != $past(dead_time) && !$past(restart) && !$past(rst))
            |-> $past(avg_valid));

    // R9: converged state holds the dead time
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (converged && !restart) |=> $stable(dead_time));

    // R8: convergence is declared only on an update
    a_r8_conv_on_update: assert property (@(posedge clk) disable iff (rst)
        $rose(converged) |-> $past(avg_valid));
endmodule

bind dt_grad_tracker dtg_checker #(.DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .avg_valid(avg_valid),
    .dead_time(dead_time),
    .step_size(step_size),
    .dt_min   (dt_min),
    .dt_max   (dt_max),
    .converged(converged)
);

// File: tb/sim_dt_grad_tracker.sv
`timescale 1ns/1ps
module sim_dt_grad_tracker;
    localparam int CUR_W = 12;
    localparam int DT_W  = 10;
    localparam int AVG_K = 2;
    localparam int NVEC  = 11;

    typedef struct packed {
        logic [CUR_W-1:0] avg;
        logic [DT_W-1:0]  dt;
        logic             dir;
        logic             conv;
    } vec_t;

    // step 10, band 5, limits 20..100, start 100
    localparam vec_t VEC [NVEC] = '{
        '{12'd500, 10'd90, 1'b1, 1'b0},  // R3 probe down
        '{12'd480, 10'd80, 1'b1, 1'b0},  // R4 fall keeps dir
        '{12'd460, 10'd70, 1'b1, 1'b0},  // R4
        '{12'd462, 10'd70, 1'b1, 1'b0},  // R6 inside band
        '{12'd440, 10'd60, 1'b1, 1'b0},  // R4
        '{12'd450, 10'd70, 1'b0, 1'b0},  // R5 rise reverses
        '{12'd445, 10'd70, 1'b0, 1'b0},  // R6 equal to band
        '{12'd430, 10'd80, 1'b0, 1'b0},  // R4 breaks chain
        '{12'd440, 10'd70, 1'b1, 1'b0},  // R5
        '{12'd450, 10'd70, 1'b0, 1'b1},  // R8 second reversal
        '{12'd300, 10'd70, 1'b0, 1'b1}   // R9 frozen
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             restart = 1'b0;
    logic             cur_valid = 1'b0;
    logic [CUR_W-1:0] cur_sample = '0;
    logic [DT_W-1:0]  step_size = 10'd10;
    logic [DT_W-1:0]  dt_min = 10'd20;
    logic [DT_W-1:0]  dt_max = 10'd100;
    logic [CUR_W-1:0] dead_band = 12'd5;
    logic [DT_W-1:0]  dead_time;
    logic             dir_down;
    logic             converged;

    int  n_run  = 0;
    int  n_fail = 0;
    logic done  = 1'b0;

    always #2 clk = ~clk;

    dt_grad_tracker #(.CUR_W(CUR_W), .DT_W(DT_W), .AVG_K(AVG_K)) u0 (
        .clk(clk), .rst(rst), .restart(restart), .cur_valid(cur_valid),
        .cur_sample(cur_sample), .step_size(step_size), .dt_min(dt_min),
        .dt_max(dt_max), .dead_band(dead_band), .dead_time(dead_time),
        .dir_down(dir_down), .converged(converged)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [CUR_W-1:0] v);
        @(negedge clk);
        cur_sample = v;
        cur_valid  = 1'b1;
        @(negedge clk);
        cur_valid  = 1'b0;
    endtask

    // four unequal samples whose mean is m
    task automatic feed(input int m);
        send(CUR_W'(m - 1));
        send(CUR_W'(m + 1));
        send(CUR_W'(m - 2));
        send(CUR_W'(m + 2));
        repeat (3) @(negedge clk);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset dead_time", dead_time, 100);
        check("R1 reset dir_down", dir_down, 1);
        check("R1 reset converged", converged, 0);

        for (int i = 0; i < NVEC; i++) begin
            feed(int'(VEC[i].avg));
            check($sformatf("vec%0d dead_time R4/R5/R6/R8", i), dead_time, int'(VEC[i].dt));
            check($sformatf("vec%0d dir_down R5/R8", i), dir_down, int'(VEC[i].dir));
            check($sformatf("vec%0d converged R8/R9", i), converged, int'(VEC[i].conv));
        end

        // R1: restart clears convergence
        do_restart();
        check("R1 restart dead_time", dead_time, 100);
        check("R1 restart dir_down", dir_down, 1);
        check("R1 restart converged", converged, 0);

        // R2: three samples give no update, the fourth does
        send(12'd500); send(12'd500); send(12'd500);
        repeat (3) @(negedge clk);
        check("R2 three samples no step", dead_time, 100);
        send(12'd500);
        repeat (3) @(negedge clk);
        check("R2 fourth sample probe step", dead_time, 90);

        // R7: lower clamp
        dt_min = 10'd85;
        do_restart();
        feed(500);
        check("R7 probe above min", dead_time, 90);
        feed(400);
        check("R7 clamp to min", dead_time, 85);
        feed(300);
        check("R7 hold at min", dead_time, 85);

        // R7: upper clamp with large step
        dt_min = 10'd20;
        step_size = 10'd30;
        do_restart();
        feed(500);
        check("R3 probe step 30", dead_time, 70);
        feed(520);
        check("R5 reverse up to max", dead_time, 100);
        check("R5 dir up", dir_down, 0);
        feed(510);
        check("R7 clamp to max", dead_time, 100);
        check("R8 no conv after fall", converged, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule